// File: doc/BRIEF.md
# Hot-Plug Slot Register Controller

This block holds the slot capability, slot control and slot status registers of a switch downstream port or root port that supports hot-plug. System software reaches them through a dword configuration port with per-byte enables. The read data is combinational on the address. The hardware side reports device insertion, the presence of a device at power-up, and presses of the attention button. The block returns a message request (MSI-X or MSI) with a 5-bit vector, a level legacy interrupt line, a detach request and a link-active flag.

The block keeps the hot-plug event bits and derives a single notification level from them and from their enables. It signals only when that level changes. Every write to slot control counts as one command. The block completes each command at once and reports it through the command-completed event. A lock-control bit in slot control toggles the electromechanical interlock status. A status write that tries to clear event bits that were never set is treated as a racy software bug and is undone. When software powers the slot down, with power control on and the power indicator off, the block asks for the device to be detached.

The slot dword has control in bits [15:0] and status in bits [31:16]. The capability dword is read-only.

Top module: `hpslot_ctrl`

## Requirements
- R1: The slot dword reads 0x000000C0 after reset when no device is present at boot. The attention indicator reads off (11b), and every enable, the power indicator, power control, lock status and all event bits read 0. When boot_present_i is 1 during reset, presence (status bit 6) and link_active_o read 1 and no event bit is set. msg_req_o, intx_o and detach_req_o are 0.
- R2: The capability dword reads {MSG_NUM[4:0] at 31:27, SLOT_NUM[7:0] at 26:19, interlock present at bit 17, hot-plug capable bit 6, hot-plug surprise bit 5, power indicator present bit 4, attention indicator present bit 3, power controller present bit 1, attention button present bit 0}. Writes to it are ignored, and so are writes to any other address.
- R3: Writes update only the writable control fields: bit 0 button enable, bit 3 presence-change enable, bit 4 command-completed enable, bit 5 hot-plug interrupt enable, [7:6] attention indicator, [9:8] power indicator, bit 10 power control. Each byte changes only when its byte enable is set. Lock control (bit 11) always reads 0.
- R4: Any write that touches the control half (byte enable 0 or 1) sets command-completed (status bit 4). The bit is visible after the second clock edge that follows the write.
- R5: Writing 1 to lock control with byte enable 1 toggles lock status (status bit 7) at the write edge.
- R6: Status event bits 0 to 4 (button, power fault, sensor change, presence change, command completed) clear when written 1. If the write carries a 1 for any event bit that is currently 0, all event bits keep their values.
- R7: The notification level is the hot-plug interrupt enable ANDed with the OR, over event bits 0, 3 and 4, of status bit AND enable bit.
- R8: A one-cycle msg_req_o fires, one edge after the level's inputs change, only when the level changes and MSI-X or MSI is enabled. msg_msix_o is 1 when MSI-X is enabled and 0 otherwise, and msg_vec_o carries MSG_NUM.
- R9: With both message types disabled, intx_o takes the level when the level changes and drops whenever the level is low. No message is requested.
- R10: Raising an event whose status bits are all already set causes no new message.
- R11: If presence is set and a control write makes power control 1 with power indicator 11b, and that was not already so, the block pulses detach_req_o. It clears presence and link_active_o and sets presence-change.
- R12: An insertion pulse sets presence and link_active_o and sets presence-change and button events. A button pulse sets the button event.
- R13: Interrupt masking is not considered: an event pending while notification is disabled produces a message once software enables it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| cfg_wr_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | ADDR_W | Dword address for read and write |
| cfg_be_i | input | 4 | Byte enables of the write |
| cfg_wdata_i | input | 32 | Write data |
| cfg_rdata_o | output | 32 | Read data for cfg_addr_i |
| boot_present_i | input | 1 | Device present at power-up, sampled during reset |
| insert_i | input | 1 | Device insertion pulse |
| button_i | input | 1 | Attention button pulse |
| msix_en_i | input | 1 | MSI-X enabled |
| msi_en_i | input | 1 | MSI enabled |
| msg_req_o | output | 1 | One-cycle message request |
| msg_msix_o | output | 1 | Message type of the last request (1 = MSI-X) |
| msg_vec_o | output | 5 | Interrupt message number |
| intx_o | output | 1 | Legacy interrupt level |
| detach_req_o | output | 1 | One-cycle detach request |
| link_active_o | output | 1 | Data-link-layer active flag |

## Verification
The bench builds the block with MSG_NUM = 19, SLOT_NUM = 42 and the capability and slot dwords at addresses 5 and 6. These are values other than the defaults, so a swapped or truncated field in the capability word or on the vector output shows up. The two addresses sit next to each other, and the bench writes to the neighbour address, so faulty address decoding is caught. Running reset once with a device present at boot and once without covers both the boot-presence path and the power-down detach, which depends on presence being set.

// File: rtl/hpslot_pkg.sv
package hpslot_pkg;

  localparam int HALF_W    = 16;
  localparam int SLOTNUM_W = 8;
  localparam int VEC_W     = 5;

  // control half field positions (software decodes these)
  localparam int C_BTN_EN  = 0;
  localparam int C_PRS_EN  = 3;
  localparam int C_CMD_EN  = 4;
  localparam int C_HP_IE   = 5;
  localparam int C_ATTN_LO = 6;
  localparam int C_PIND_LO = 8;
  localparam int C_PWR     = 10;
  localparam int C_LOCK    = 11;

  // status half field positions
  localparam int S_BTN    = 0;
  localparam int S_PRSCHG = 3;
  localparam int S_CMD    = 4;
  localparam int S_PRS    = 6;
  localparam int S_LOCK   = 7;

  typedef logic [HALF_W-1:0] half_t;

  localparam half_t EVENT_BITS  = 16'h001F;  // write-1-to-clear events
  localparam half_t NOTIFY_BITS = 16'h0019;  // events that may notify
  localparam half_t CTL_WMASK   = 16'h07F9;  // stored writable control bits
  localparam half_t CTL_RESET   = 16'h00C0;  // attention indicator off

  localparam logic [1:0] IND_OFF = 2'b11;

  function automatic half_t be_merge(input half_t old, input half_t wd,
                                     input logic [1:0] be);
    return {be[1] ? wd[15:8] : old[15:8], be[0] ? wd[7:0] : old[7:0]};
  endfunction

  function automatic logic notify_level(input half_t ctl, input half_t sta);
    return ctl[C_HP_IE] & (|(ctl & sta & NOTIFY_BITS));
  endfunction

  // clearing a bit that was never set undoes the whole write
  function automatic half_t status_w1c(input half_t cur, input half_t wd);
    if (|(wd & ~cur & EVENT_BITS)) return cur;
    return cur & ~(wd & EVENT_BITS);
  endfunction

  function automatic logic powered_down(input half_t ctl);
    return ctl[C_PWR] && (ctl[C_PIND_LO +: 2] == IND_OFF);
  endfunction

endpackage

// File: rtl/hpslot_ctl_reg.sv
module hpslot_ctl_reg
  import hpslot_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] be_i,
  input  half_t      wdata_i,
  input  logic       present_i,
  output half_t      ctl_o,
  output logic       lock_flip_o,
  output logic       detach_evt_o,
  output logic       detach_req_o,
  output logic       cmd_done_o
);

  half_t ctl_q;
  half_t ctl_new;
  logic  detach_q;
  logic  cmd_q;

  always_comb begin
    ctl_new = (ctl_q & ~CTL_WMASK) | (be_merge(ctl_q, wdata_i, be_i) & CTL_WMASK);
  end

  // lock control is never stored: a written 1 only flips the status
  assign lock_flip_o  = wr_i & be_i[1] & wdata_i[C_LOCK];
  assign detach_evt_o = wr_i & present_i & powered_down(ctl_new) & ~powered_down(ctl_q);

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      ctl_q    <= CTL_RESET;
      detach_q <= 1'b0;
      cmd_q    <= 1'b0;
    end else begin
      if (wr_i) ctl_q <= ctl_new;
      detach_q <= detach_evt_o;
      cmd_q    <= wr_i;
    end
  end

  assign ctl_o        = ctl_q;
  assign detach_req_o = detach_q;
  assign cmd_done_o   = cmd_q;

endmodule

// File: rtl/hpslot_sta_reg.sv
module hpslot_sta_reg
  import hpslot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  boot_present_i,
  input  logic  insert_i,
  input  logic  button_i,
  input  logic  wr_i,
  input  half_t wdata_i,
  input  logic  lock_flip_i,
  input  logic  detach_evt_i,
  input  logic  cmd_done_i,
  output half_t sta_o,
  output logic  link_o
);

  half_t sta_q;
  half_t sta_d;
  logic  link_q;
  logic  link_d;

  always_comb begin
    sta_d  = sta_q;
    link_d = link_q;
    if (wr_i) sta_d = status_w1c(sta_q, wdata_i);
    if (lock_flip_i) sta_d[S_LOCK] = ~sta_q[S_LOCK];
    if (detach_evt_i) begin
      sta_d[S_PRS]    = 1'b0;
      sta_d[S_PRSCHG] = 1'b1;
      link_d          = 1'b0;
    end
    if (insert_i) begin
      sta_d[S_PRS]    = 1'b1;
      sta_d[S_PRSCHG] = 1'b1;
      sta_d[S_BTN]    = 1'b1;
      link_d          = 1'b1;
    end
    if (button_i)   sta_d[S_BTN] = 1'b1;
    if (cmd_done_i) sta_d[S_CMD] = 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      sta_q  <= half_t'(boot_present_i) << S_PRS;
      link_q <= boot_present_i;
    end else begin
      sta_q  <= sta_d;
      link_q <= link_d;
    end
  end

  assign sta_o  = sta_q;
  assign link_o = link_q;

endmodule

// File: rtl/hpslot_notify.sv
module hpslot_notify
  import hpslot_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  half_t ctl_i,
  input  half_t sta_i,
  input  logic  msix_en_i,
  input  logic  msi_en_i,
  output logic  lvl_now_o,
  output logic  lvl_seen_o,
  output logic  msg_req_o,
  output logic  msg_msix_o,
  output logic  intx_o
);

  logic lvl_q;
  logic req_q;
  logic kind_q;
  logic intx_q;
  logic changed;
  logic legacy;

  assign lvl_now_o = notify_level(ctl_i, sta_i);
  assign changed   = lvl_now_o ^ lvl_q;
  assign legacy    = ~msix_en_i & ~msi_en_i;

  always_ff @(posedge clk_i) begin
    if (!rst_ni) begin
      lvl_q  <= 1'b0;
      req_q  <= 1'b0;
      kind_q <= 1'b0;
      intx_q <= 1'b0;
    end else begin
      lvl_q <= lvl_now_o;
      req_q <= changed & ~legacy;
      if (changed & ~legacy) kind_q <= msix_en_i;
      if (legacy) intx_q <= lvl_now_o & (changed | intx_q);
    end
  end

  assign lvl_seen_o = lvl_q;
  assign msg_req_o  = req_q;
  assign msg_msix_o = kind_q;
  assign intx_o     = intx_q;

endmodule

// File: rtl/hpslot_ctrl.sv
module hpslot_ctrl
  import hpslot_pkg::*;
#(
  parameter int ADDR_W    = 10,
  parameter int CAP_ADDR  = 6,
  parameter int SLOT_ADDR = 7,
  parameter int SLOT_NUM  = 0,
  parameter int MSG_NUM   = 0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cfg_wr_i,
  input  logic [ADDR_W-1:0] cfg_addr_i,
  input  logic [3:0]        cfg_be_i,
  input  logic [31:0]       cfg_wdata_i,
  output logic [31:0]       cfg_rdata_o,
  input  logic              boot_present_i,
  input  logic              insert_i,
  input  logic              button_i,
  input  logic              msix_en_i,
  input  logic              msi_en_i,
  output logic              msg_req_o,
  output logic              msg_msix_o,
  output logic [VEC_W-1:0]  msg_vec_o,
  output logic              intx_o,
  output logic              detach_req_o,
  output logic              link_active_o
);

  localparam logic [ADDR_W-1:0] CAP_A  = ADDR_W'(CAP_ADDR);
  localparam logic [ADDR_W-1:0] SLOT_A = ADDR_W'(SLOT_ADDR);
  // low bits: button, power ctl, attn ind, power ind, surprise, capable
  localparam logic [6:0]  CAP_FLAGS = 7'b1111011;
  localparam logic [31:0] CAP_WORD  = {VEC_W'(MSG_NUM), SLOTNUM_W'(SLOT_NUM),
                                       1'b0, 1'b1, 10'b0, CAP_FLAGS};

  logic  slot_hit;
  logic  ctl_hit;
  logic  sta_hit;
  half_t sta_wd;
  half_t ctl_w;
  half_t sta_w;
  logic  lock_flip;
  logic  detach_evt;
  logic  cmd_done;
  logic  lvl_now;
  logic  lvl_seen;
  logic  unused_hi;

  assign slot_hit  = cfg_wr_i && (cfg_addr_i == SLOT_A);
  assign ctl_hit   = slot_hit && (|cfg_be_i[1:0]);
  assign sta_hit   = slot_hit && (|cfg_be_i[3:2]);
  assign sta_wd    = {8'h00, cfg_be_i[2] ? cfg_wdata_i[23:16] : 8'h00};
  assign unused_hi = ^cfg_wdata_i[31:24];

  hpslot_ctl_reg u_ctl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .wr_i         (ctl_hit),
    .be_i         (cfg_be_i[1:0]),
    .wdata_i      (cfg_wdata_i[15:0]),
    .present_i    (sta_w[S_PRS]),
    .ctl_o        (ctl_w),
    .lock_flip_o  (lock_flip),
    .detach_evt_o (detach_evt),
    .detach_req_o (detach_req_o),
    .cmd_done_o   (cmd_done)
  );

  hpslot_sta_reg u_sta (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .boot_present_i (boot_present_i),
    .insert_i       (insert_i),
    .button_i       (button_i),
    .wr_i           (sta_hit),
    .wdata_i        (sta_wd),
    .lock_flip_i    (lock_flip),
    .detach_evt_i   (detach_evt),
    .cmd_done_i     (cmd_done),
    .sta_o          (sta_w),
    .link_o         (link_active_o)
  );

  hpslot_notify u_ntf (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ctl_i      (ctl_w),
    .sta_i      (sta_w),
    .msix_en_i  (msix_en_i),
    .msi_en_i   (msi_en_i),
    .lvl_now_o  (lvl_now),
    .lvl_seen_o (lvl_seen),
    .msg_req_o  (msg_req_o),
    .msg_msix_o (msg_msix_o),
    .intx_o     (intx_o)
  );

  always_comb begin
    if (cfg_addr_i == CAP_A)       cfg_rdata_o = CAP_WORD;
    else if (cfg_addr_i == SLOT_A) cfg_rdata_o = {sta_w, ctl_w};
    else                           cfg_rdata_o = 32'h0;
  end

  assign msg_vec_o = VEC_W'(MSG_NUM);

endmodule

// File: rtl/hpslot_ctrl_chk.sv
module hpslot_ctrl_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic ctl_hit_i,
  input logic be1_i,
  input logic lock_bit_i,
  input logic insert_i,
  input logic msix_en_i,
  input logic msi_en_i,
  input logic msg_req_i,
  input logic intx_i,
  input logic detach_req_i,
  input logic lvl_now_i,
  input logic lvl_seen_i,
  input logic cmd_sta_i,
  input logic prs_i,
  input logic lock_sta_i
);

  // R4
  cmd_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctl_hit_i |=> ##1 cmd_sta_i);

  // R5
  lock_toggle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ctl_hit_i && be1_i && lock_bit_i) |=> (lock_sta_i != $past(lock_sta_i)));

  // R8
  msg_on_change_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_i |-> (lvl_seen_i != $past(lvl_seen_i)));

  // R8
  msg_needs_enable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    msg_req_i |-> ($past(msix_en_i) || $past(msi_en_i)));

  // R9
  intx_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!msix_en_i && !msi_en_i && !lvl_now_i) |=> !intx_i);

  // R11
  detach_clears_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    detach_req_i |-> (!prs_i || $past(insert_i)));

endmodule

bind hpslot_ctrl hpslot_ctrl_chk u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ctl_hit_i    (ctl_hit),
  .be1_i        (cfg_be_i[1]),
  .lock_bit_i   (cfg_wdata_i[11]),
  .insert_i     (insert_i),
  .msix_en_i    (msix_en_i),
  .msi_en_i     (msi_en_i),
  .msg_req_i    (msg_req_o),
  .intx_i       (intx_o),
  .detach_req_i (detach_req_o),
  .lvl_now_i    (lvl_now),
  .lvl_seen_i   (lvl_seen),
  .cmd_sta_i    (sta_w[4]),
  .prs_i        (sta_w[6]),
  .lock_sta_i   (sta_w[7])
);

// File: tb/test_hpslot_ctrl.sv
module test_hpslot_ctrl;

  localparam int AW = 10;
  localparam int CAPA = 5;
  localparam int SLOTA = 6;
  localparam int SNUM = 42;
  localparam int VNUM = 19;
  localparam logic [31:0] EXP_CAP = {5'(VNUM), 8'(SNUM), 1'b0, 1'b1, 10'b0, 7'b1111011};
  localparam int NV = 14;

  // entry: write addr, byte enables, write data, read addr, expected read
  localparam logic [87:0] VEC [NV] = '{
    {10'd6, 4'b0011, 32'h0000_00F1, 10'd6, 32'h0050_00F1}, // R3 R4 enables, cmd done
    {10'd6, 4'b0100, 32'h0010_0000, 10'd6, 32'h0040_00F1}, // R6 clear cmd done
    {10'd6, 4'b0001, 32'h0000_00F1, 10'd6, 32'h0050_00F1}, // R4 low byte only
    {10'd6, 4'b0100, 32'h0012_0000, 10'd6, 32'h0050_00F1}, // R6 revert, fault bit was 0
    {10'd6, 4'b0100, 32'h0010_0000, 10'd6, 32'h0040_00F1}, // R6 clear
    {10'd6, 4'b0010, 32'h0000_0800, 10'd6, 32'h00D0_00F1}, // R5 lock on, reads 0
    {10'd6, 4'b0010, 32'h0000_0800, 10'd6, 32'h0050_00F1}, // R5 lock off
    {10'd6, 4'b0100, 32'h0010_0000, 10'd6, 32'h0040_00F1}, // R6 clear
    {10'd6, 4'b0010, 32'h0000_0172, 10'd6, 32'h0050_01F1}, // R3 byte 0 masked
    {10'd6, 4'b0100, 32'h0010_0000, 10'd6, 32'h0040_01F1}, // R6 clear
    {10'd6, 4'b0010, 32'h0000_0700, 10'd6, 32'h0018_07F1}, // R11 power-down detach
    {10'd6, 4'b0010, 32'h0000_0700, 10'd6, 32'h0018_07F1}, // R11 no repeat
    {10'd5, 4'b1111, 32'hFFFF_FFFF, 10'd5, EXP_CAP},       // R2 cap read-only
    {10'd7, 4'b1111, 32'hFFFF_FFFF, 10'd6, 32'h0018_07F1}  // R2 other address
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic boot_p = 1'b1;
  logic ins = 1'b0;
  logic btn = 1'b0;
  logic msix = 1'b0;
  logic msi = 1'b0;
  logic msg_req, msg_msix, intx, detach, link;
  logic [4:0] vec;

  int n_chk = 0;
  int n_fail = 0;
  int msg_cnt = 0;
  int det_cnt = 0;
  logic last_msix = 1'b0;
  logic [4:0] last_vec = '0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  hpslot_ctrl #(.ADDR_W(AW), .CAP_ADDR(CAPA), .SLOT_ADDR(SLOTA),
                .SLOT_NUM(SNUM), .MSG_NUM(VNUM)) i_hpslot_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cfg_wr_i(wr), .cfg_addr_i(addr),
    .cfg_be_i(be), .cfg_wdata_i(wdata), .cfg_rdata_o(rdata),
    .boot_present_i(boot_p), .insert_i(ins), .button_i(btn),
    .msix_en_i(msix), .msi_en_i(msi), .msg_req_o(msg_req),
    .msg_msix_o(msg_msix), .msg_vec_o(vec), .intx_o(intx),
    .detach_req_o(detach), .link_active_o(link)
  );

  always @(negedge clk) begin
    if (msg_req) begin
      msg_cnt <= msg_cnt + 1;
      last_msix <= msg_msix;
      last_vec <= vec;
    end
    if (detach) det_cnt <= det_cnt + 1;
  end

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  task automatic cfg_write(input logic [AW-1:0] a, input logic [3:0] b, input logic [31:0] d);
    @(negedge clk);
    addr = a; be = b; wdata = d; wr = 1'b1;
    @(negedge clk);
    wr = 1'b0; be = '0;
    settle();
  endtask

  task automatic cfg_read(input logic [AW-1:0] a, output logic [31:0] d);
    @(negedge clk);
    addr = a;
    #1 d = rdata;
  endtask

  task automatic pulse_insert();
    @(negedge clk); ins = 1'b1;
    @(negedge clk); ins = 1'b0;
    settle();
  endtask

  task automatic pulse_button();
    @(negedge clk); btn = 1'b1;
    @(negedge clk); btn = 1'b0;
    settle();
  endtask

  task automatic do_reset(input logic present);
    @(negedge clk);
    boot_p = present; rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    settle();
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int base;
    do_reset(1'b1);
    cfg_read(10'(SLOTA), rd);
    check("R1 reset slot dword, boot present", rd, 32'h0040_00C0);
    check("R1 link after boot presence", {31'b0, link}, 32'd1);
    check("R1 outputs idle", {29'b0, msg_req, intx, detach}, 32'd0);
    cfg_read(10'(CAPA), rd);
    check("R2 capability dword", rd, EXP_CAP);
    check("R8 vector pin", {27'b0, vec}, 32'(VNUM));

    for (int i = 0; i < NV; i++) begin
      cfg_write(VEC[i][87:78], VEC[i][77:74], VEC[i][73:42]);
      cfg_read(VEC[i][41:32], rd);
      check($sformatf("R3-table entry %0d", i), rd, VEC[i][31:0]);
    end
    check("R11 one detach pulse", 32'(det_cnt), 32'd1);
    check("R11 link cleared", {31'b0, link}, 32'd0);

    do_reset(1'b0);
    cfg_read(10'(SLOTA), rd);
    check("R1 reset slot dword, empty", rd, 32'h0000_00C0);
    check("R1 link empty", {31'b0, link}, 32'd0);

    base = msg_cnt;
    pulse_insert();
    cfg_read(10'(SLOTA), rd);
    check("R12 insertion status", rd, 32'h0049_00C0);
    check("R12 insertion link", {31'b0, link}, 32'd1);
    check("R13 no message while disabled", 32'(msg_cnt - base), 32'd0);

    msix = 1'b1; msi = 1'b1;
    cfg_write(10'(SLOTA), 4'b0001, 32'h0000_00E8);
    check("R13 pending event signals on enable", 32'(msg_cnt - base), 32'd1);
    check("R8 MSI-X preferred", {31'b0, last_msix}, 32'd1);
    check("R8 vector carried", {27'b0, last_vec}, 32'(VNUM));
    cfg_read(10'(SLOTA), rd);
    check("R4 status after enable write", rd, 32'h0059_00E8);

    pulse_insert();
    check("R10 repeat event no message", 32'(msg_cnt - base), 32'd1);

    msix = 1'b0;
    cfg_write(10'(SLOTA), 4'b0100, 32'h0008_0000);
    check("R8 falling level message", 32'(msg_cnt - base), 32'd2);
    check("R8 MSI type", {31'b0, last_msix}, 32'd0);
    cfg_read(10'(SLOTA), rd);
    check("R6 presence-change cleared", rd, 32'h0051_00E8);

    msi = 1'b0;
    cfg_write(10'(SLOTA), 4'b0100, 32'h0011_0000);
    cfg_write(10'(SLOTA), 4'b0001, 32'h0000_00E9);
    check("R9 intx low before button", {31'b0, intx}, 32'd0);
    pulse_button();
    check("R9 intx follows level", {31'b0, intx}, 32'd1);
    check("R9 no message in legacy mode", 32'(msg_cnt - base), 32'd2);
    cfg_write(10'(SLOTA), 4'b0100, 32'h0001_0000);
    check("R9 intx drops on clear", {31'b0, intx}, 32'd0);
    pulse_button();
    check("R12 button raises level", {31'b0, intx}, 32'd1);
    cfg_write(10'(SLOTA), 4'b0001, 32'h0000_00C9);
    check("R7 interrupt enable gates level", {31'b0, intx}, 32'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end

endmodule